// File: doc/BRIEF.md
# Decimating Speech Record and Playback Controller

This block captures speech from an audio codec into an on-chip byte store and plays it back. The codec side delivers one 18-bit signed sample per frame and marks each frame with a single-cycle ready strobe at 48 kHz. While the record button is held, the block keeps one sample out of every eight strobes (6 kHz). It keeps only the top byte of that sample and writes the byte to the store at ascending addresses. When the button is released, the block reads the stored bytes back at the same 6 kHz rate. It widens each byte into an 18-bit output sample for the codec.

The store depth is set by `ADDR_W`. A value of 16 gives 65536 bytes, which is about 11 seconds of speech. The default of 11 keeps elaboration small. The button input passes through a synchronizer, so a press or release takes effect a few cycles after the pin changes. The block assumes that successive ready strobes are at least two clock cycles apart, which any real codec frame rate satisfies.

Top module: `speech_recorder`

## Requirements
- R1: A stored byte is bits [17:10] of the 18-bit input sample present at a capturing strobe. Playback reproduces the bytes in the order they were captured.
- R2: Counting from the first ready strobe after a mode change, strobes number 0, 8, 16, … are the active beats. The other strobes neither store, advance the address nor change the output.
- R3: The output sample is the stored byte in bits [17:10] with bits [9:0] zero. It changes only in the cycle after an active beat and otherwise holds its value.
- R4: After each change between record and playback, which follows the synchronized button, the address and the beat counter restart at zero. The output keeps its value until the next active beat.
- R5: Recording stops after the last address (2^ADDR_W − 1) is written. Later beats in the same take overwrite nothing.
- R6: In playback, the address wraps to 0 after the highest address written in the latest take has been output.
- R7: If the latest take captured no sample, every playback active beat drives the output to zero.
- R8: In record mode, every active beat drives the output to zero.
- R9: The store write enable comes from a register and is high for exactly one clock per captured sample. The write address and data are registered with it.
- R10: After reset the output is zero, the block is in playback mode and no take is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| recBtn | input | 1 | Record button, high while held (debounced elsewhere) |
| readyStb | input | 1 | One-cycle codec frame strobe at 48 kHz |
| sampleIn | input | 18 | Signed sample from the codec, valid on readyStb |
| sampleOut | output | 18 | Signed sample to the codec, updated only after active beats |

## Verification
An active beat sampled at clock edge E has its output in place right after E, because a single output register sits between the strobe and the pin. The monitor compares the output against the front of the scoreboard queue shortly after every edge at which a strobe was sampled. In every other cycle it checks that the output equals the last expected value, which covers the hold rule of R3 and R4. A byte captured at a strobe reaches the store one cycle later and can only be observed when it is played back. Mode switches are followed by several idle cycles so that the synchronizer delay never lines up with a strobe.

// File: rtl/speech_rec_pkg.sv
package speech_rec_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic capture;   // register a byte for writing to the store
    logic present;   // load the prefetched byte into the output
    logic mute;      // drive the output to zero
  } recStrobe_t;

endpackage

// File: rtl/speech_rec_sync.sv
module speech_rec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/speech_rec_ctrl.sv
module speech_rec_ctrl
  import speech_rec_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DECIM  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              recMode,
  input  logic              readyStb,
  output recStrobe_t        strb,
  output logic [ADDR_W-1:0] addr
);

  localparam int DIV_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(DECIM - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] lastAddr;
  logic              hasData;
  logic              full;
  logic              modePrev;
  logic              modeChange;
  logic              onBeat;

  assign modeChange = recMode != modePrev;
  assign onBeat     = readyStb && (divCnt == '0) && !modeChange;

  always_comb begin
    strb         = '0;
    strb.capture = onBeat && recMode && !full;
    strb.present = onBeat && !recMode && hasData;
    strb.mute    = onBeat && (recMode || !hasData);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modePrev <= 1'b0;
      divCnt   <= '0;
      addr     <= '0;
      lastAddr <= '0;
      hasData  <= 1'b0;
      full     <= 1'b0;
    end else begin
      modePrev <= recMode;
      if (modeChange) begin
        divCnt <= '0;
        addr   <= '0;
        full   <= 1'b0;
        if (recMode) hasData <= 1'b0;
      end else begin
        if (readyStb) divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
        if (strb.capture) begin
          lastAddr <= addr;
          hasData  <= 1'b1;
          if (addr == ADDR_LAST) full <= 1'b1;
          else                   addr <= addr + 1'b1;
        end
        if (strb.present) addr <= (addr == lastAddr) ? '0 : addr + 1'b1;
      end
    end
  end

  AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (rst)
    modeChange |=> (addr == '0)) else $error("address not restarted"); // R4
  AST_BEAT_ON_READY: assert property (@(posedge clk) disable iff (rst)
    (strb.capture || strb.present || strb.mute) |-> readyStb) else $error("beat without strobe"); // R2
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !strb.capture) else $error("write past end"); // R5
  AST_PLAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (strb.present && addr == lastAddr) |=> (addr == '0)) else $error("no wrap"); // R6
  AST_EMPTY_MUTE: assert property (@(posedge clk) disable iff (rst)
    (!recMode && !hasData) |-> !strb.present) else $error("playing empty take"); // R7

endmodule

// File: rtl/speech_rec_dp.sv
module speech_rec_dp
  import speech_rec_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int STORE_W  = 8,
  parameter int ADDR_W   = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  recStrobe_t                 strb,
  input  logic [ADDR_W-1:0]          addr,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = SAMPLE_W - STORE_W;

  logic [STORE_W-1:0]  store [DEPTH];
  logic                wrEn;
  logic [ADDR_W-1:0]   wrAddr;
  logic [STORE_W-1:0]  wrData;
  logic [STORE_W-1:0]  rdData;
  logic [SAMPLE_W-1:0] outReg;

  // Write port registered so enable, address and data settle together
  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strb.capture;
      if (strb.capture) begin
        wrAddr <= addr;
        wrData <= sampleIn[SAMPLE_W-1 -: STORE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[addr];
  end

  always_ff @(posedge clk) begin
    if (rst)               outReg <= '0;
    else if (strb.present) outReg <= {rdData, {PAD_W{1'b0}}};
    else if (strb.mute)    outReg <= '0;
  end

  assign sampleOut = outReg;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !wrEn) else $error("write enable wider than a cycle"); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strb.present || strb.mute) |=> $stable(sampleOut)) else $error("output moved off beat"); // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    sampleOut[PAD_W-1:0] == '0) else $error("low bits not zero"); // R3

endmodule

// File: rtl/speech_recorder.sv
module speech_recorder
  import speech_rec_pkg::*;
#(
  parameter int SAMPLE_W    = 18,
  parameter int STORE_W     = 8,
  parameter int ADDR_W      = 11,
  parameter int DECIM       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       recBtn,
  input  logic                       readyStb,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  logic              recMode;
  recStrobe_t        strb;
  logic [ADDR_W-1:0] addr;

  speech_rec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (recBtn),
    .dout (recMode)
  );

  speech_rec_ctrl #(.ADDR_W(ADDR_W), .DECIM(DECIM)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .recMode  (recMode),
    .readyStb (readyStb),
    .strb     (strb),
    .addr     (addr)
  );

  speech_rec_dp #(.SAMPLE_W(SAMPLE_W), .STORE_W(STORE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .addr      (addr),
    .sampleIn  (sampleIn),
    .sampleOut (sampleOut)
  );

endmodule

// File: tb/speech_recorder_bench.sv
module speech_recorder_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int DEC   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic recBtn = 1'b0;
  logic readyStb = 1'b0;
  logic signed [17:0] sampleIn = '0;
  wire  signed [17:0] sampleOut;

  always #4 clk = ~clk;

  speech_recorder #(.ADDR_W(AW)) u_speech_recorder (
    .clk(clk), .rst(rst), .recBtn(recBtn), .readyStb(readyStb),
    .sampleIn(sampleIn), .sampleOut(sampleOut)
  );

  typedef struct { logic [17:0] v; string tag; } item_t;
  item_t expQ[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model state
  logic [7:0]  modelMem [DEPTH];
  int          mIdx = 0, mLast = 0, mCnt = 0;
  bit          mHas = 0, mFull = 0, mRec = 0;
  logic [17:0] modelOut = '0;

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: sampleOut=%h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one codec strobe, model update, expected item queued
  task automatic beat(input logic [17:0] s, input string tag);
    item_t it;
    @(negedge clk);
    sampleIn = s;
    readyStb = 1'b1;
    it.v = modelOut;
    it.tag = "R2";
    if (mCnt == 0) begin
      if (mRec) begin
        it.v = '0; it.tag = "R8";
        if (!mFull) begin
          modelMem[mIdx] = s[17:10];
          mLast = mIdx; mHas = 1;
          if (mIdx == DEPTH-1) mFull = 1; else mIdx++;
        end
      end else if (!mHas) begin
        it.v = '0; it.tag = "R7";
      end else begin
        it.v = {modelMem[mIdx], 10'b0}; it.tag = tag;
        mIdx = (mIdx == mLast) ? 0 : mIdx + 1;
      end
    end
    mCnt = (mCnt + 1) % DEC;
    modelOut = it.v;
    expQ.push_back(it);
    @(negedge clk);
    readyStb = 1'b0;
    sampleIn = 18'h2A5A5;
    repeat (2) @(negedge clk);
  endtask

  task automatic setMode(input bit rec);
    @(negedge clk);
    recBtn = rec;
    repeat (6) @(negedge clk);
    mRec = rec; mIdx = 0; mCnt = 0; mFull = 0;
    if (rec) mHas = 0;
  endtask

  function automatic logic [17:0] mk(input int k);
    return 18'((k * 7919 + 12345) ^ (k << 11) ^ 18'h155);
  endfunction

  // Monitor: pops on strobe cycles, checks hold on all others
  logic [17:0] held = '0;
  bit sawStb;
  always @(posedge clk) begin
    sawStb = readyStb;
    #2;
    if (!rst && !done) begin
      if (sawStb) begin
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R2: sampleOut=%h expected no strobe result", sampleOut);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(sampleOut, it.v, it.tag);
          held = it.v;
        end
      end else begin
        check(sampleOut, held, "R3");
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: sampleOut=%h expected completion", sampleOut);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sampleOut, '0, "R10");
    // R7 and R10: playback with nothing stored
    for (int i = 0; i < 2*DEC; i++) beat(mk(i), "R7");
    // R1/R2: record five bytes, off-beat samples differ
    setMode(1);
    for (int i = 0; i < 5*DEC; i++) beat(mk(100 + i), "R8");
    // R1, R6, R9: play back with wrap after the fifth byte
    setMode(0);
    for (int i = 0; i < 8*DEC; i++) beat(mk(i), "R6");
    // R5: overfill the store, then play it twice round
    setMode(1);
    for (int i = 0; i < (DEPTH + 4)*DEC; i++) beat(mk(500 + 3*i), "R8");
    setMode(0);
    for (int i = 0; i < (DEPTH + 4)*DEC; i++) beat(mk(i), "R5");
    // R4: leave playback mid-count, first strobe of the new take captures
    for (int i = 0; i < 3; i++) beat(mk(i), "R4");
    setMode(1);
    for (int i = 0; i < 2*DEC + 1; i++) beat(mk(900 + i), "R4");
    setMode(0);
    for (int i = 0; i < 5*DEC; i++) beat(mk(i), "R4");
    // R7: empty take after a full one
    setMode(1);
    setMode(0);
    for (int i = 0; i < 2*DEC; i++) beat(mk(i), "R7");
    repeat (4) @(negedge clk);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R3: pending results=%0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule